// File: doc/BRIEF.md
# Indirect Register Access Bridge

This block gives a host a narrow, three-item window onto a small internal register space. The host writes an address register to pick one of sixteen internal byte locations. It then moves bytes through a single data register. A busy flag, which is also bit 7 of the address register, shows that an internal transfer is in progress. Every internal transfer, read or write, takes a fixed number of clock cycles.

The internal space holds several kinds of byte. Two six-byte banks (a capture value and an alarm value) hold 47-bit quantities whose lowest bit is not implemented. There is also a control byte and an oscillator-control byte. Finally there is an index register and a data port that together reach a 64-byte backup RAM. Two features make multi-byte accesses cheaper. First, the address steps forward by itself after each access to a bank byte. Second, an optional read-ahead mode starts the next internal read as soon as the host has read the data register. All internal locations are plain storage here; counting, alarm matching and oscillator logic live elsewhere.

Top module: `ibr_bridge`

## Requirements
- R1: After synchronous reset the address register reads 0x00, the data register reads 0x00, busy is 0, and every internal byte, including all of the backup RAM, holds 0x00.
- R2: A host address-register write loads bits 3:0 as the internal address and bit 6 as the read-ahead enable. The address register reads back as {busy, read-ahead, 2'b00, address}, so bits 5:4 always read 0.
- R3: An address-register write with bit 7 set starts an internal read of the new address. Busy is 1 for exactly 4 cycles after the write edge. When busy clears, the data register holds the addressed internal byte.
- R4: A host data-register write places the written byte in the data register and starts an internal write of that byte to the current address. Busy is 1 for exactly 4 cycles, and the byte is stored when busy clears.
- R5: Once an internal read or write of address 0x00–0x05 (capture bank) or 0x08–0x0D (alarm bank) completes, the address field has increased by one.
- R6: Once an internal access to 0x06 (control), 0x07 (oscillator control), 0x0E (RAM index) or 0x0F (RAM data port) completes, the address field is unchanged.
- R7: With read-ahead enabled, a host read strobe on the data register while busy is 0 starts an internal read of the current address, with the same 4-cycle busy and result as R3.
- R8: With read-ahead disabled, a host read strobe on the data register starts nothing: busy stays 0 and both host registers keep their values.
- R9: Any host write or read strobe given while busy is 1 is ignored. It changes neither the address register, the data register, the transfer in progress, nor internal storage.
- R10: Bit 0 of capture byte 0x00 and of alarm byte 0x08 is discarded on write and reads as 0. All other bank bits store fully.
- R11: The RAM index at 0x0E keeps only the low 6 bits of a written byte and reads as {2'b00, index}. An access to 0x0F reads or writes the RAM byte the index selects, and it leaves the index unchanged.
- R12: The control byte 0x06 and the oscillator-control byte 0x07 each store and return all 8 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr_we | input | 1 | Host write strobe for the address register |
| host_data_we | input | 1 | Host write strobe for the data register |
| host_data_re | input | 1 | Host read strobe for the data register (marks that the host consumed it) |
| host_wdata | input | 8 | Host write byte |
| addr_reg_q | output | 8 | Address register readback {busy, read-ahead, 00, address} |
| data_reg_q | output | 8 | Data register readback |
| busy | output | 1 | Internal transfer in progress |

## Verification
Directed sequences cover several cases. One walks a full six-byte bank write followed by a read-ahead readback, which separates correct stepping from a stuck or doubly stepped address. Another hits the four non-stepping addresses, the masked bits (bank bit 0, index bits 7:6) and strobes given mid-transfer, which separates ignoring from queueing or corruption. A long run of seeded random address writes, data writes and read strobes then hits every address with mixed read-ahead settings. Each of these is compared against a bench model of the sixteen locations and the RAM, so that a wrong decode, a wrong priority or a wrong completion cycle shows up as a mismatch in the address or data byte.

// File: rtl/ibr_pkg.sv
package ibr_pkg;

    parameter int IADDR_W    = 4;
    parameter int BANK_BYTES = 6;
    parameter int RAM_BYTES  = 64;
    parameter int XFER_CYC   = 4;

    localparam int RIDX_W = $clog2(RAM_BYTES);

    localparam logic [IADDR_W-1:0] A_CAP_LO  = 4'h0;
    localparam logic [IADDR_W-1:0] A_CTRL    = 4'h6;
    localparam logic [IADDR_W-1:0] A_OSC     = 4'h7;
    localparam logic [IADDR_W-1:0] A_ALM_LO  = 4'h8;
    localparam logic [IADDR_W-1:0] A_RAMIDX  = 4'hE;
    localparam logic [IADDR_W-1:0] A_RAMDAT  = 4'hF;

    localparam int AUTO_BIT = 6;
    localparam int GO_BIT   = 7;

    typedef enum logic {
        OP_RD = 1'b0,
        OP_WR = 1'b1
    } op_e;

    typedef enum logic [2:0] {
        RG_CAP,
        RG_CTRL,
        RG_OSC,
        RG_ALM,
        RG_RIDX,
        RG_RDAT
    } region_e;

    typedef struct packed {
        logic                busy;
        logic                auto_rd;
        logic [1:0]          rsvd;
        logic [IADDR_W-1:0]  addr;
    } addr_view_t;

    function automatic region_e decode(input logic [IADDR_W-1:0] a);
        region_e r;
        if (a < A_CTRL)            r = RG_CAP;
        else if (a == A_CTRL)      r = RG_CTRL;
        else if (a == A_OSC)       r = RG_OSC;
        else if (a < A_RAMIDX)     r = RG_ALM;
        else if (a == A_RAMIDX)    r = RG_RIDX;
        else                       r = RG_RDAT;
        return r;
    endfunction

    function automatic logic steps_after(input logic [IADDR_W-1:0] a);
        region_e r;
        r = decode(a);
        return (r == RG_CAP) || (r == RG_ALM);
    endfunction

endpackage

// File: rtl/ibr_store.sv
module ibr_store
    import ibr_pkg::*;
#(
    parameter int NBYTES = BANK_BYTES,
    parameter int RDEPTH = RAM_BYTES
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [IADDR_W-1:0] acc_addr,
    input  logic [7:0]         wr_byte,
    output logic [7:0]         rd_byte
);

    localparam int IW = $clog2(RDEPTH);

    logic [7:0]    cap_q [NBYTES];
    logic [7:0]    alm_q [NBYTES];
    logic [7:0]    ctrl_q;
    logic [7:0]    osc_q;
    logic [IW-1:0] ridx_q;
    logic [7:0]    ram_q [RDEPTH];

    region_e                 rg;
    logic [IADDR_W-1:0]      cap_off;
    logic [IADDR_W-1:0]      alm_off;

    always_comb begin
        rg      = decode(acc_addr);
        cap_off = acc_addr - A_CAP_LO;
        alm_off = acc_addr - A_ALM_LO;
    end

    // Timer banks: byte 0 of each bank drops its lowest bit.
    for (genvar g = 0; g < NBYTES; g++) begin : g_bank
        localparam logic [7:0] KEEP = (g == 0) ? 8'hFE : 8'hFF;

        always_ff @(posedge clk) begin
            if (rst) begin
                cap_q[g] <= '0;
                alm_q[g] <= '0;
            end else if (wr_en) begin
                if (rg == RG_CAP && cap_off == IADDR_W'(g))
                    cap_q[g] <= wr_byte & KEEP;
                if (rg == RG_ALM && alm_off == IADDR_W'(g))
                    alm_q[g] <= wr_byte & KEEP;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            osc_q  <= '0;
            ridx_q <= '0;
        end else if (wr_en) begin
            case (rg)
                RG_CTRL: ctrl_q <= wr_byte;
                RG_OSC:  osc_q  <= wr_byte;
                RG_RIDX: ridx_q <= wr_byte[IW-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < RDEPTH; i++) ram_q[i] <= '0;
        end else if (wr_en && rg == RG_RDAT) begin
            ram_q[ridx_q] <= wr_byte;
        end
    end

    always_comb begin
        rd_byte = '0;
        case (rg)
            RG_CAP:  rd_byte = cap_q[cap_off[$clog2(NBYTES)-1:0]];
            RG_ALM:  rd_byte = alm_q[alm_off[$clog2(NBYTES)-1:0]];
            RG_CTRL: rd_byte = ctrl_q;
            RG_OSC:  rd_byte = osc_q;
            RG_RIDX: rd_byte = 8'(ridx_q);
            RG_RDAT: rd_byte = ram_q[ridx_q];
            default: rd_byte = '0;
        endcase
    end

endmodule

// File: rtl/ibr_seq.sv
module ibr_seq
    import ibr_pkg::*;
#(
    parameter int XFER = XFER_CYC
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               addr_we,
    input  logic               data_we,
    input  logic               data_re,
    input  logic [7:0]         wbyte,
    input  logic [7:0]         st_rd_byte,
    output logic               st_wr_en,
    output logic [IADDR_W-1:0] st_addr,
    output logic [7:0]         st_wr_byte,
    output logic [IADDR_W-1:0] addr_q,
    output logic               auto_q,
    output logic [7:0]         data_q,
    output logic               busy
);

    localparam int CNT_W = $clog2(XFER + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(XFER);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    op_e              op_q;
    logic             finish;

    always_comb begin
        busy       = (cnt_q != '0);
        finish     = (cnt_q == CNT_LAST);
        st_addr    = addr_q;
        st_wr_byte = data_q;
        st_wr_en   = finish && (op_q == OP_WR);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            op_q   <= OP_RD;
            addr_q <= '0;
            auto_q <= 1'b0;
            data_q <= '0;
        end else if (busy) begin
            cnt_q <= cnt_q - CNT_LAST;
            if (finish) begin
                if (op_q == OP_RD) data_q <= st_rd_byte;
                if (steps_after(addr_q)) addr_q <= addr_q + IADDR_W'(1);
            end
        end else if (addr_we) begin
            addr_q <= wbyte[IADDR_W-1:0];
            auto_q <= wbyte[AUTO_BIT];
            if (wbyte[GO_BIT]) begin
                cnt_q <= CNT_LOAD;
                op_q  <= OP_RD;
            end
        end else if (data_we) begin
            data_q <= wbyte;
            cnt_q  <= CNT_LOAD;
            op_q   <= OP_WR;
        end else if (data_re && auto_q) begin
            cnt_q <= CNT_LOAD;
            op_q  <= OP_RD;
        end
    end

endmodule

// File: rtl/ibr_bridge.sv
module ibr_bridge
    import ibr_pkg::*;
#(
    parameter int XFER   = XFER_CYC,
    parameter int NBYTES = BANK_BYTES,
    parameter int RDEPTH = RAM_BYTES
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       host_addr_we,
    input  logic       host_data_we,
    input  logic       host_data_re,
    input  logic [7:0] host_wdata,
    output logic [7:0] addr_reg_q,
    output logic [7:0] data_reg_q,
    output logic       busy
);

    logic               st_wr_en;
    logic [IADDR_W-1:0] st_addr;
    logic [7:0]         st_wr_byte;
    logic [7:0]         st_rd_byte;
    logic [IADDR_W-1:0] addr_q;
    logic               auto_q;
    addr_view_t         view;

    ibr_seq #(.XFER(XFER)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .addr_we    (host_addr_we),
        .data_we    (host_data_we),
        .data_re    (host_data_re),
        .wbyte      (host_wdata),
        .st_rd_byte (st_rd_byte),
        .st_wr_en   (st_wr_en),
        .st_addr    (st_addr),
        .st_wr_byte (st_wr_byte),
        .addr_q     (addr_q),
        .auto_q     (auto_q),
        .data_q     (data_reg_q),
        .busy       (busy)
    );

    ibr_store #(.NBYTES(NBYTES), .RDEPTH(RDEPTH)) u_store (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (st_wr_en),
        .acc_addr (st_addr),
        .wr_byte  (st_wr_byte),
        .rd_byte  (st_rd_byte)
    );

    always_comb begin
        view.busy    = busy;
        view.auto_rd = auto_q;
        view.rsvd    = 2'b00;
        view.addr    = addr_q;
        addr_reg_q   = view;
    end

endmodule

// File: rtl/ibr_bridge_chk.sv
module ibr_bridge_chk
    import ibr_pkg::*;
#(
    parameter int XFER = XFER_CYC
) (
    input logic       clk,
    input logic       rst,
    input logic       host_addr_we,
    input logic       host_data_we,
    input logic       host_data_re,
    input logic [7:0] host_wdata,
    input logic [7:0] addr_reg_q,
    input logic [7:0] data_reg_q,
    input logic       busy
);

    int unsigned busy_run;

    always_ff @(posedge clk) begin
        if (rst) busy_run <= 0;
        else if (busy) busy_run <= busy_run + 1;
        else busy_run <= 0;
    end

    AST_BUSY_EXACT: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> busy_run == XFER);                               // R3
    AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (rst)
        busy |-> busy_run < XFER);                                       // R4
    AST_VIEW_FIELDS: assert property (@(posedge clk) disable iff (rst)
        addr_reg_q[5:4] == 2'b00 && addr_reg_q[7] == busy);              // R2
    AST_STEP_BANK: assert property (@(posedge clk) disable iff (rst)
        ($fell(busy) && steps_after($past(addr_reg_q[3:0])))
        |-> addr_reg_q[3:0] == $past(addr_reg_q[3:0]) + 4'd1);           // R5
    AST_HOLD_OTHER: assert property (@(posedge clk) disable iff (rst)
        ($fell(busy) && !steps_after($past(addr_reg_q[3:0])))
        |-> addr_reg_q[3:0] == $past(addr_reg_q[3:0]));                  // R6
    AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (rst)
        (busy && busy_run + 1 < XFER && (host_addr_we || host_data_we))
        |=> $stable(addr_reg_q[6:0]));                                   // R9
    AST_NO_AUTO_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!busy && host_data_re && !addr_reg_q[6] && !host_addr_we && !host_data_we)
        |=> !busy);                                                      // R8

endmodule

bind ibr_bridge ibr_bridge_chk #(.XFER(XFER)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .host_addr_we (host_addr_we),
    .host_data_we (host_data_we),
    .host_data_re (host_data_re),
    .host_wdata   (host_wdata),
    .addr_reg_q   (addr_reg_q),
    .data_reg_q   (data_reg_q),
    .busy         (busy)
);

// File: tb/ibr_bridge_bench.sv
module ibr_bridge_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       host_addr_we = 1'b0;
    logic       host_data_we = 1'b0;
    logic       host_data_re = 1'b0;
    logic [7:0] host_wdata = '0;
    logic [7:0] addr_reg_q;
    logic [7:0] data_reg_q;
    logic       busy;

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    ibr_bridge u_ibr_bridge (
        .clk          (clk),
        .rst          (rst),
        .host_addr_we (host_addr_we),
        .host_data_we (host_data_we),
        .host_data_re (host_data_re),
        .host_wdata   (host_wdata),
        .addr_reg_q   (addr_reg_q),
        .data_reg_q   (data_reg_q),
        .busy         (busy)
    );

    // Reference model
    logic [7:0] m_cap [6];
    logic [7:0] m_alm [6];
    logic [7:0] m_ctrl, m_osc;
    logic [5:0] m_ridx;
    logic [7:0] m_ram [64];
    logic [3:0] m_addr;
    logic       m_auto;
    logic [7:0] m_data;

    function automatic logic m_steps(input logic [3:0] a);
        return (a <= 4'h5) || (a >= 4'h8 && a <= 4'hD);
    endfunction

    function automatic logic [7:0] m_read(input logic [3:0] a);
        if (a <= 4'h5) return m_cap[a];
        if (a == 4'h6) return m_ctrl;
        if (a == 4'h7) return m_osc;
        if (a <= 4'hD) return m_alm[a - 4'h8];
        if (a == 4'hE) return {2'b00, m_ridx};
        return m_ram[m_ridx];
    endfunction

    task automatic m_write(input logic [3:0] a, input logic [7:0] v);
        if (a <= 4'h5)      m_cap[a] = (a == 4'h0) ? (v & 8'hFE) : v;
        else if (a == 4'h6) m_ctrl = v;
        else if (a == 4'h7) m_osc = v;
        else if (a <= 4'hD) m_alm[a - 4'h8] = (a == 4'h8) ? (v & 8'hFE) : v;
        else if (a == 4'hE) m_ridx = v[5:0];
        else                m_ram[m_ridx] = v;
    endtask

    task automatic m_reset();
        for (int i = 0; i < 6; i++) begin m_cap[i] = '0; m_alm[i] = '0; end
        for (int i = 0; i < 64; i++) m_ram[i] = '0;
        m_ctrl = '0; m_osc = '0; m_ridx = '0;
        m_addr = '0; m_auto = 1'b0; m_data = '0;
    endtask

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // kind: 0 address write, 1 data write, 2 data read strobe
    task automatic host_op(input int kind, input logic [7:0] v, input string req);
        logic start;
        @(negedge clk);
        host_wdata   = v;
        host_addr_we = (kind == 0);
        host_data_we = (kind == 1);
        host_data_re = (kind == 2);
        @(negedge clk);
        host_addr_we = 1'b0; host_data_we = 1'b0; host_data_re = 1'b0;
        start = 1'b0;
        if (kind == 0) begin
            m_addr = v[3:0]; m_auto = v[6]; start = v[7];
        end else if (kind == 1) begin
            start = 1'b1; m_data = v;
        end else begin
            start = m_auto;
        end
        check({req, " busy-start"}, 8'(busy), 8'(start));
        if (start) begin
            repeat (4) @(negedge clk);
            if (kind == 1) m_write(m_addr, v);
            else m_data = m_read(m_addr);
            if (m_steps(m_addr)) m_addr = m_addr + 4'd1;
        end
        check({req, " addr"}, addr_reg_q, {1'b0, m_auto, 2'b00, m_addr});
        check({req, " data"}, data_reg_q, m_data);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] v;
        m_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 addr", addr_reg_q, 8'h00);
        check("R1 data", data_reg_q, 8'h00);
        check("R1 busy", 8'(busy), 8'h00);
        host_op(0, 8'h8E, "R1 ridx");
        host_op(0, 8'h8F, "R1 ram");

        // R2: field load and reserved bits
        host_op(0, 8'h4A, "R2 load");
        check("R2 view", addr_reg_q, 8'h4A);
        host_op(0, 8'h35, "R2 rsvd");
        check("R2 rsvd view", addr_reg_q, 8'h05);

        // R4 R5 R10: fill the capture bank, stepping through it
        host_op(0, 8'h00, "R4 set addr");
        for (int i = 0; i < 6; i++) host_op(1, 8'hF1 + 8'(i * 16), "R4 R5 cap write");
        check("R5 past bank", addr_reg_q, 8'h06);
        // R3 R7 R10: read it back with read-ahead
        host_op(0, 8'hC0, "R3 go");
        check("R10 cap0 bit0", data_reg_q, 8'hF0);
        for (int i = 0; i < 5; i++) host_op(2, 8'h00, "R7 read-ahead");
        check("R7 last cap", data_reg_q, 8'h41);

        // R10: alarm bank
        host_op(0, 8'h08, "R10 set");
        host_op(1, 8'h03, "R10 alm0 write");
        host_op(1, 8'h03, "R10 alm1 write");
        host_op(0, 8'h88, "R10 alm0 read");
        check("R10 alm0 bit0", data_reg_q, 8'h02);
        host_op(0, 8'h89, "R10 alm1 read");
        check("R10 alm1 bit0", data_reg_q, 8'h03);

        // R6 R12: control and oscillator bytes
        host_op(0, 8'h06, "R6 set ctrl");
        host_op(1, 8'hA5, "R6 R12 ctrl write");
        host_op(0, 8'h87, "R12 osc go");
        host_op(1, 8'h5A, "R6 R12 osc write");
        host_op(0, 8'h86, "R12 ctrl read");
        check("R12 ctrl", data_reg_q, 8'hA5);

        // R11: index mask and data port
        host_op(0, 8'h0E, "R11 set idx");
        host_op(1, 8'hFF, "R11 idx write");
        host_op(0, 8'h8E, "R11 idx read");
        check("R11 idx mask", data_reg_q, 8'h3F);
        host_op(0, 8'h0F, "R11 port");
        host_op(1, 8'h77, "R11 port write");
        host_op(1, 8'h78, "R11 port write2");
        host_op(0, 8'h8F, "R11 port read");
        check("R11 ram", data_reg_q, 8'h78);
        host_op(0, 8'h8E, "R11 idx kept");
        check("R11 idx kept", data_reg_q, 8'h3F);

        // R8: read strobe without read-ahead
        host_op(0, 8'h07, "R8 set");
        host_op(2, 8'h00, "R8 strobe");

        // R9: strobes during a transfer are ignored
        @(negedge clk);
        host_wdata = 8'h86; host_addr_we = 1'b1;
        @(negedge clk);
        host_addr_we = 1'b0;
        m_addr = 4'h6; m_auto = 1'b0;
        @(negedge clk);
        host_wdata = 8'h4C; host_addr_we = 1'b1;
        @(negedge clk);
        host_addr_we = 1'b0; host_wdata = 8'h11; host_data_we = 1'b1;
        @(negedge clk);
        host_data_we = 1'b0;
        check("R9 busy held", 8'(busy), 8'h01);
        @(negedge clk);
        m_data = m_read(m_addr);
        check("R9 addr", addr_reg_q, {1'b0, m_auto, 2'b00, m_addr});
        check("R9 data", data_reg_q, m_data);
        host_op(0, 8'h86, "R9 ctrl intact");
        check("R9 ctrl", data_reg_q, 8'hA5);

        // Seeded random mix
        v = 8'($urandom(32'h5EED_1234));
        for (int n = 0; n < 600; n++) begin
            int k;
            k = $urandom_range(0, 2);
            v = 8'($urandom);
            if (k == 0 && $urandom_range(0, 3) != 0) v[7] = 1'b1;
            host_op(k, v, "R5 R6 R7 random");
        end

        $display("Result: errors=%0d of %0d checks", n_fail, n_chk);
        $finish;
    end

endmodule